// File: doc/BRIEF.md
# Gated Ternary Prefix Lookup Table

This block is a 64-entry, 32-bit ternary match table for longest-prefix lookup, for example finding a route for a packet's destination address. Each entry has two parts. The upper four bits are an unmaskable binary head. The lower 28 bits form a ternary body, and each body bit has its own don't-care flag. Software loads the table longest prefix first, starting at index 0. A search presents a key. The block reports whether any entry matched and, if so, the lowest matching index.

Every entry checks its head before its body. The head is compared bit by bit from the most significant bit down. The body comparison of an entry is enabled only when all four head bits equal the key and the entry is valid. With each result the block reports how many entries passed that head gate. It also keeps a running total of those counts and a count of searches. Together these show what share of entries the head check alone removed from full evaluation.

Writes use a single 32-bit bus and two separate strobes, one for entry data and one for the body don't-care flags. A search is sampled on a clock edge, and its result appears on the outputs after that same edge.

Top module: `pfx_stage_lookup`

## Requirements
- R1: Synchronous active-high reset clears res_valid, hit, hit_idx, gate_cnt, gate_total and search_total to 0, and marks every entry invalid. After reset, no key matches any entry, including the key 0x00000000.
- R2: When srch_en is sampled high on a clock edge, res_valid is 1 after that edge. Without a search, res_valid is 0 and hit, hit_idx, gate_cnt and gate_total keep their values.
- R3: An entry whose head (stored bits 31:28) differs from key bits 31:28 never matches, even if every body bit is don't-care.
- R4: For body bit i (bits 27:0), a don't-care flag of 1 always matches. A flag of 0 matches only when the stored bit equals key bit i.
- R5: When several entries match, hit_idx is the lowest matching index.
- R6: When no entry matches, hit is 0 and hit_idx is 0.
- R7: A data write stores wr_valid as the entry's valid flag. An invalid entry never matches and never passes the head gate.
- R8: A data write (wr_data_en) stores wr_bus bits 31:0 as head and body and leaves the don't-care flags unchanged. A mask write (wr_mask_en) stores wr_bus bits 27:0 as the body don't-care flags. It ignores bus bits 31:28 and leaves data and valid unchanged.
- R9: A search in the same cycle as a write to the same entry sees the contents from before the write. The written entry is searchable from the next cycle on.
- R10: gate_cnt equals the number of valid entries whose head equals key bits 31:28.
- R11: Each search adds gate_cnt to gate_total, which wraps modulo 2^32, and adds 1 to search_total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data_en | input | 1 | Write head, body and valid flag of entry wr_addr |
| wr_mask_en | input | 1 | Write body don't-care flags of entry wr_addr |
| wr_addr | input | 6 | Entry index for a write |
| wr_bus | input | 32 | Shared write data bus |
| wr_valid | input | 1 | Valid flag stored by a data write |
| srch_en | input | 1 | Start a search with srch_key |
| srch_key | input | 32 | Search key |
| res_valid | output | 1 | A search result is on the outputs this cycle |
| hit | output | 1 | Some entry matched the last key |
| hit_idx | output | 6 | Lowest matching index, 0 on a miss |
| gate_cnt | output | 7 | Entries that passed the head gate in the last search |
| gate_total | output | 32 | Running sum of gate_cnt |
| search_total | output | 32 | Number of searches since reset |

## Verification
The assertions assume that inputs are stable around the clock edge. They also assume that srch_en and the write strobes are 0 or 1 and never unknown. They make no assumption about whether writes and searches overlap, so the bench drives every input on the falling edge and deliberately places one write and one search in the same cycle. Both strobes never fire in the same cycle on the same entry except where R8 is exercised. Otherwise a single expected-value model would need to merge two updates.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    localparam int ENTRIES = 64;
    localparam int WORD_W  = 32;
    localparam int HEAD_W  = 4;
    localparam int TOT_W   = 32;
    localparam int BODY_W  = WORD_W - HEAD_W;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int CNT_W   = $clog2(ENTRIES + 1);

    // One stored row: valid flag, binary head, ternary body and its don't-care flags
    typedef struct packed {
        logic              valid;
        logic [HEAD_W-1:0] head;
        logic [BODY_W-1:0] body;
        logic [BODY_W-1:0] dc;
    } entry_t;

    typedef entry_t [ENTRIES-1:0] table_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] gates;
    } result_t;

    function automatic logic [CNT_W-1:0] count_set(input logic [ENTRIES-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            n = n + CNT_W'(v[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/pfx_entry_store.sv
module pfx_entry_store
    import pfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_data_en,
    input  logic              wr_mask_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_bus,
    input  logic              wr_valid,
    output table_t            tbl_o
);
    table_t tbl_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl_q[g] <= '0;
            end else begin
                if (wr_data_en && wr_addr == IDX_W'(g)) begin
                    tbl_q[g].valid <= wr_valid;
                    tbl_q[g].head  <= wr_bus[WORD_W-1:BODY_W];
                    tbl_q[g].body  <= wr_bus[BODY_W-1:0];
                end
                if (wr_mask_en && wr_addr == IDX_W'(g)) begin
                    tbl_q[g].dc <= wr_bus[BODY_W-1:0];
                end
            end
        end
    end

    assign tbl_o = tbl_q;

    // R7: the valid flag follows the value carried by a data write
    assert_write_valid_R7: assert property (@(posedge clk) disable iff (rst)
        wr_data_en |=> tbl_q[$past(wr_addr)].valid == $past(wr_valid));
endmodule

// File: rtl/pfx_match_row.sv
module pfx_match_row
    import pfx_pkg::*;
(
    input  entry_t            entry_i,
    input  logic [WORD_W-1:0] key_i,
    output logic              gate_o,
    output logic              match_o
);
    // Head compared from the top bit down; a break anywhere stops the chain
    logic [HEAD_W:0] chain;
    logic            body_ok;

    assign chain[0] = entry_i.valid;
    for (genvar i = 0; i < HEAD_W; i++) begin : g_head
        assign chain[i+1] = chain[i] &
            ~(entry_i.head[HEAD_W-1-i] ^ key_i[WORD_W-1-i]);
    end

    assign gate_o = chain[HEAD_W];

    // Body compare is only enabled when the head gate is open
    always_comb begin
        body_ok = 1'b0;
        if (gate_o) begin
            body_ok = ~|((entry_i.body ^ key_i[BODY_W-1:0]) & ~entry_i.dc);
        end
    end

    assign match_o = gate_o & body_ok;
endmodule

// File: rtl/pfx_prio_pick.sv
module pfx_prio_pick
    import pfx_pkg::*;
(
    input  logic [ENTRIES-1:0] req_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pfx_stage_lookup.sv
module pfx_stage_lookup
    import pfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_data_en,
    input  logic              wr_mask_en,
    input  logic [5:0]        wr_addr,
    input  logic [31:0]       wr_bus,
    input  logic              wr_valid,
    input  logic              srch_en,
    input  logic [31:0]       srch_key,
    output logic              res_valid,
    output logic              hit,
    output logic [5:0]        hit_idx,
    output logic [6:0]        gate_cnt,
    output logic [31:0]       gate_total,
    output logic [31:0]       search_total
);
    table_t             tbl;
    logic [ENTRIES-1:0] gate_vec;
    logic [ENTRIES-1:0] match_vec;
    logic               pick_hit;
    logic [IDX_W-1:0]   pick_idx;
    logic [CNT_W-1:0]   gate_now;
    result_t            res_q;
    logic               rv_q;
    logic [TOT_W-1:0]   gsum_q;
    logic [TOT_W-1:0]   scnt_q;

    pfx_entry_store u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_data_en (wr_data_en),
        .wr_mask_en (wr_mask_en),
        .wr_addr    (wr_addr),
        .wr_bus     (wr_bus),
        .wr_valid   (wr_valid),
        .tbl_o      (tbl)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        pfx_match_row u_row (
            .entry_i (tbl[g]),
            .key_i   (srch_key),
            .gate_o  (gate_vec[g]),
            .match_o (match_vec[g])
        );
    end

    pfx_prio_pick u_pick (
        .req_i (match_vec),
        .hit_o (pick_hit),
        .idx_o (pick_idx)
    );

    assign gate_now = count_set(gate_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            rv_q   <= 1'b0;
            gsum_q <= '0;
            scnt_q <= '0;
        end else begin
            rv_q <= srch_en;
            if (srch_en) begin
                res_q.hit   <= pick_hit;
                res_q.idx   <= pick_hit ? pick_idx : '0;
                res_q.gates <= gate_now;
                gsum_q      <= gsum_q + TOT_W'(gate_now);
                scnt_q      <= scnt_q + 1'b1;
            end
        end
    end

    assign res_valid    = rv_q;
    assign hit          = res_q.hit;
    assign hit_idx      = res_q.idx;
    assign gate_cnt     = res_q.gates;
    assign gate_total   = gsum_q;
    assign search_total = scnt_q;

    // Entries below the picked index, used by the priority check
    logic [ENTRIES-1:0] below_pick;
    assign below_pick = (ENTRIES'(1) << pick_idx) - ENTRIES'(1);

    assert_lowest_pick_R5: assert property (@(posedge clk) disable iff (rst)
        pick_hit |-> (match_vec[pick_idx] && (match_vec & below_pick) == '0));

    assert_miss_idx_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !hit |-> hit_idx == '0);

    assert_hit_has_gate_R10: assert property (@(posedge clk) disable iff (rst)
        hit |-> gate_cnt != '0);

    assert_search_step_R11: assert property (@(posedge clk) disable iff (rst)
        srch_en |=> search_total == $past(search_total) + 1'b1);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !srch_en |=> (!res_valid && $stable(gate_total) && $stable(hit)
                      && $stable(hit_idx) && $stable(gate_cnt)));
endmodule

// File: tb/tb_pfx_stage_lookup.sv
`timescale 1ns/1ps
module tb_pfx_stage_lookup;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_data_en, wr_mask_en, wr_valid, srch_en;
    logic [5:0]  wr_addr;
    logic [31:0] wr_bus, srch_key;
    logic        res_valid, hit;
    logic [5:0]  hit_idx;
    logic [6:0]  gate_cnt;
    logic [31:0] gate_total, search_total;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] exp_gsum = '0;
    logic [31:0] exp_scnt = '0;

    always #2.5 clk = ~clk;

    pfx_stage_lookup dut (
        .clk(clk), .rst(rst), .wr_data_en(wr_data_en), .wr_mask_en(wr_mask_en),
        .wr_addr(wr_addr), .wr_bus(wr_bus), .wr_valid(wr_valid),
        .srch_en(srch_en), .srch_key(srch_key), .res_valid(res_valid),
        .hit(hit), .hit_idx(hit_idx), .gate_cnt(gate_cnt),
        .gate_total(gate_total), .search_total(search_total)
    );

    typedef struct packed {
        logic [5:0]  addr;
        logic        valid;
        logic [31:0] data;
        logic [27:0] dc;
    } load_t;

    // Table image; entry 5 is loaded invalid (R7)
    localparam load_t LOADS [6] = '{
        '{6'd0, 1'b1, 32'hA1234567, 28'h0000000},
        '{6'd1, 1'b1, 32'hA1230000, 28'h000FFFF},
        '{6'd2, 1'b1, 32'hA0000000, 28'hFFFFFFF},
        '{6'd3, 1'b1, 32'h50000000, 28'hFFFFFFF},
        '{6'd4, 1'b1, 32'h5ABC0000, 28'h000FFFF},
        '{6'd5, 1'b0, 32'hC0000000, 28'hFFFFFFF}
    };

    typedef struct packed {
        logic [31:0] key;
        logic        hit;
        logic [5:0]  idx;
        logic [6:0]  gates;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'hA1234567, 1'b1, 6'd0, 7'd3},   // exact body, R4/R5
        '{32'hA1234568, 1'b1, 6'd1, 7'd3},   // cared low bit differs in 0, R4
        '{32'hA9999999, 1'b1, 6'd2, 7'd3},   // all-don't-care body, R4
        '{32'h5ABC1234, 1'b1, 6'd3, 7'd2},   // 3 and 4 both match, R5
        '{32'h51111111, 1'b1, 6'd3, 7'd2},
        '{32'hC0000000, 1'b0, 6'd0, 7'd0},   // only an invalid entry fits, R7
        '{32'h30000000, 1'b0, 6'd0, 7'd0},   // nothing fits, R6
        '{32'hB0000000, 1'b0, 6'd0, 7'd0}    // body of 2 fits, head does not, R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_data(input logic [5:0] a, input logic [31:0] d, input logic v);
        @(negedge clk);
        wr_data_en = 1'b1; wr_addr = a; wr_bus = d; wr_valid = v;
        @(negedge clk);
        wr_data_en = 1'b0;
    endtask

    task automatic write_mask(input logic [5:0] a, input logic [31:0] m);
        @(negedge clk);
        wr_mask_en = 1'b1; wr_addr = a; wr_bus = m;
        @(negedge clk);
        wr_mask_en = 1'b0;
    endtask

    // Search, then sample one negedge later (result registered at the posedge between)
    task automatic search(input logic [31:0] k, input logic eh, input logic [5:0] ei,
                          input logic [6:0] eg, input string tag);
        @(negedge clk);
        srch_en = 1'b1; srch_key = k;
        @(negedge clk);
        srch_en = 1'b0;
        exp_gsum = exp_gsum + 32'(eg);
        exp_scnt = exp_scnt + 1;
        check({tag, " R2 res_valid"}, 32'(res_valid), 32'd1);
        check({tag, " R5 hit"}, 32'(hit), 32'(eh));
        check({tag, " R6 hit_idx"}, 32'(hit_idx), 32'(ei));
        check({tag, " R10 gate_cnt"}, 32'(gate_cnt), 32'(eg));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_data_en = 0; wr_mask_en = 0; wr_valid = 0; srch_en = 0;
        wr_addr = '0; wr_bus = '0; srch_key = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 res_valid", 32'(res_valid), 0);
        check("R1 hit", 32'(hit), 0);
        check("R1 gate_cnt", 32'(gate_cnt), 0);
        check("R1 gate_total", gate_total, 0);
        check("R1 search_total", search_total, 0);
        search(32'h00000000, 1'b0, 6'd0, 7'd0, "R1 empty table");

        foreach (LOADS[i]) begin
            write_data(LOADS[i].addr, LOADS[i].data, LOADS[i].valid);
            write_mask(LOADS[i].addr, {4'h0, LOADS[i].dc});
        end

        foreach (VECS[i]) begin
            search(VECS[i].key, VECS[i].hit, VECS[i].idx, VECS[i].gates, $sformatf("vec%0d", i));
        end

        // R2: outputs hold while idle
        @(negedge clk);
        check("R2 idle res_valid", 32'(res_valid), 0);
        check("R2 idle hit", 32'(hit), 0);

        // R8: mask write with top bus bits set; head of entry 0 stays A
        write_mask(6'd0, 32'hFFFFFFFF);
        search(32'hA0000000, 1'b1, 6'd0, 7'd3, "R8 mask applied");
        search(32'hF0000000, 1'b0, 6'd0, 7'd0, "R8 head unchanged");

        // R9: write and search in the same cycle see old contents
        @(negedge clk);
        wr_data_en = 1'b1; wr_addr = 6'd6; wr_bus = 32'h30000000; wr_valid = 1'b1;
        srch_en = 1'b1; srch_key = 32'h30000000;
        @(negedge clk);
        wr_data_en = 1'b0; srch_en = 1'b0;
        exp_scnt = exp_scnt + 1;
        check("R9 same-cycle hit", 32'(hit), 0);
        check("R9 same-cycle gate_cnt", 32'(gate_cnt), 0);
        search(32'h30000000, 1'b1, 6'd6, 7'd1, "R9 next cycle");

        // R7: invalidate entry 6
        write_data(6'd6, 32'h30000000, 1'b0);
        search(32'h30000000, 1'b0, 6'd0, 7'd0, "R7 invalidated");

        // R11 totals
        check("R11 gate_total", gate_total, exp_gsum);
        check("R11 search_total", search_total, exp_scnt);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule